// File: doc/BRIEF.md
# Reload Timer Square-Wave Generator

This block is a timer that counts up and reloads itself, and it drives a square-wave clock output pin. A counter advances once for every two pulses of an oscillator-phase enable. When the counter passes its all-ones value it loads a programmable reload value in that same step. It does not step through zero. Each such wrap inverts an output flop. The pin therefore carries a square wave with an equal high and low time. Its period is 4 × (2^CNT_W − reload) oscillator pulses. With the default 16-bit counter and a 16 MHz oscillator this spans about 61 Hz (reload 0) up to 4 MHz (reload all ones).

The reload value is held in two byte-wide registers, high and low, that are written through a shared data bus. A one-cycle wrap strobe is also brought out. Other logic, such as a baud-rate divider, can take it as a tick, and that tick is locked to the clock-out rate.

While the output enable is set, a wrap never raises the timer interrupt flag. When the output enable is clear, the pin shows a general-purpose latch value instead, and wraps set the flag as a normal timer would.

Counting is sequenced by a small phase state machine with three states:
- PS_HALT: stopped.
- PS_EVEN: waiting for the first oscillator pulse of a pair.
- PS_ODD: waiting for the second pulse, which advances the counter.

Its transitions are:
- go_off: any state to PS_HALT when the run bit is 0 or external counting is selected.
- go_on: PS_HALT to PS_EVEN.
- half_step: PS_EVEN to PS_ODD on a pulse.
- full_step: PS_ODD to PS_EVEN on a pulse, which also advances the counter.

Top module: `clkout_timer`

## Requirements
- R1: After reset the counter, both reload bytes and the output flop are 0. With out_en = 1 the pin reads 0, and ovf_tick and tmr_flag read 0.
- R2: With ct_sel = 1 (external counting selected), the counter does not advance. ovf_tick stays 0 and the pin holds its level. Returning ct_sel to 0 resumes the toggling.
- R3: With run = 0 the counter and the output flop hold their values. No ovf_tick is produced and the pin does not change.
- R4: With run = 1, ct_sel = 0 and out_en = 1, each high time and each low time of clk_pin lasts exactly 2 × (2^CNT_W − reload) osc_en pulses. Here reload = {reload high byte, reload low byte}. This gives a 50% duty cycle.
- R5: ovf_tick is high for exactly one clock cycle per wrap. It rises in the same cycle in which the output flop inverts.
- R6: A wrap sets tmr_flag only when out_en = 0. A wrap with out_en = 1 leaves the flag at 0. flag_clr = 1 clears the flag, and a simultaneous set wins.
- R7: With out_en = 0, clk_pin equals gpio_latch.
- R8: A wr_hi pulse stores wdata into the upper byte of the reload value, and a wr_lo pulse stores it into the lower byte. Each write leaves the other byte unchanged. A new value is first used at the next wrap.
- R9: The counter advances once per two osc_en pulses, not per clock. With osc_en high on every other clock, each level of clk_pin lasts 4 × (2^CNT_W − reload) clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | Oscillator-phase enable, one pulse per oscillator period |
| run | input | 1 | 1 = timer runs, 0 = timer holds |
| ct_sel | input | 1 | 0 = internal timing, 1 = external counting (does not count here) |
| out_en | input | 1 | 1 = square wave on pin, 0 = pin shows gpio_latch |
| gpio_latch | input | 1 | General-purpose output value for the pin |
| wr_hi | input | 1 | Write strobe for the upper reload byte |
| wr_lo | input | 1 | Write strobe for the lower reload byte |
| wdata | input | CNT_W/2 | Reload byte data |
| flag_clr | input | 1 | Clears the timer overflow flag |
| clk_pin | output | 1 | Clock-out / general-purpose pin value |
| ovf_tick | output | 1 | One-cycle strobe on each wrap |
| tmr_flag | output | 1 | Timer overflow interrupt flag |

## Verification
The bench builds the block with CNT_W = 6, so each reload byte is 3 bits wide and there are only 64 reload values. This makes it practical to sweep every reload value from 0 to 63 and to compare each measured high and low time against 2 × (64 − reload) clocks. Both the longest half period (128 clocks) and the shortest (2 clocks) are covered. A second, shorter sweep with osc_en pulsing every other clock checks that the spacing scales with the enable and not with the clock. The small width also lets the flag, hold and pin-select cases each be reached within a few hundred cycles.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    typedef enum logic [1:0] {
        PS_HALT = 2'd0,
        PS_EVEN = 2'd1,
        PS_ODD  = 2'd2
    } ps_state_t;

endpackage

// File: rtl/clkout_phase.sv
module clkout_phase
    import clkout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic go,
    output logic adv
);

    ps_state_t state_q;
    ps_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: go_off, go_on, half_step, full_step
    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = PS_HALT;                       // go_off
        end else begin
            unique case (state_q)
                PS_HALT: state_d = PS_EVEN;          // go_on
                PS_EVEN: if (osc_en) state_d = PS_ODD;   // half_step
                PS_ODD:  if (osc_en) state_d = PS_EVEN;  // full_step
                default: state_d = PS_HALT;
            endcase
        end
    end

    // outputs
    always_comb begin
        adv = 1'b0;
        unique case (state_q)
            PS_HALT: adv = 1'b0;
            PS_EVEN: adv = 1'b0;
            PS_ODD:  adv = go && osc_en;
            default: adv = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkout_count.sv
module clkout_count #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [CNT_W/2-1:0]   wdata,
    output logic                 wrap
);

    localparam int BYTE_W = CNT_W / 2;

    logic [BYTE_W-1:0] rld_hi_q;
    logic [BYTE_W-1:0] rld_lo_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  reload;
    logic              at_top;

    assign reload = {rld_hi_q, rld_lo_q};
    assign at_top = (cnt_q == {CNT_W{1'b1}});
    assign wrap   = adv && at_top;

    // reload byte registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_hi_q <= '0;
            rld_lo_q <= '0;
        end else begin
            if (wr_hi) rld_hi_q <= wdata;
            if (wr_lo) rld_lo_q <= wdata;
        end
    end

    // up counter, reloads in place of passing through zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            if (at_top) cnt_q <= reload;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/clkout_wave.sv
module clkout_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic out_en,
    input  logic gpio_latch,
    input  logic flag_clr,
    output logic clk_pin,
    output logic ovf_tick,
    output logic tmr_flag
);

    logic tog_q;
    logic tick_q;
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (wrap) tog_q <= ~tog_q;
        end
    end

    // flag suppressed while the square wave is routed to the pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap && !out_en) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign clk_pin  = out_en ? tog_q : gpio_latch;
    assign ovf_tick = tick_q;
    assign tmr_flag = flag_q;

endmodule

// File: rtl/clkout_timer.sv
module clkout_timer #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_en,
    input  logic               run,
    input  logic               ct_sel,
    input  logic               out_en,
    input  logic               gpio_latch,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [CNT_W/2-1:0] wdata,
    input  logic               flag_clr,
    output logic               clk_pin,
    output logic               ovf_tick,
    output logic               tmr_flag
);

    logic go;
    logic adv;
    logic wrap;

    assign go = run && !ct_sel;

    clkout_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .go     (go),
        .adv    (adv)
    );

    clkout_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .wr_hi (wr_hi),
        .wr_lo (wr_lo),
        .wdata (wdata),
        .wrap  (wrap)
    );

    clkout_wave u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .out_en     (out_en),
        .gpio_latch (gpio_latch),
        .flag_clr   (flag_clr),
        .clk_pin    (clk_pin),
        .ovf_tick   (ovf_tick),
        .tmr_flag   (tmr_flag)
    );

endmodule

// File: rtl/clkout_chk.sv
module clkout_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic ct_sel,
    input logic out_en,
    input logic gpio_latch,
    input logic clk_pin,
    input logic ovf_tick,
    input logic tmr_flag
);

    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !ovf_tick);                                        // R3

    AST_STOP_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run) && $stable(out_en) && $stable(gpio_latch)) |-> $stable(clk_pin)); // R3

    AST_EXT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ct_sel) |-> !ovf_tick);                                      // R2

    AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_tick && out_en && $past(out_en)) |-> (clk_pin != $past(clk_pin))); // R5

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_tick |=> !ovf_tick);                                           // R5

    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_flag) |-> !$past(out_en));                               // R6

endmodule

bind clkout_timer clkout_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .ct_sel     (ct_sel),
    .out_en     (out_en),
    .gpio_latch (gpio_latch),
    .clk_pin    (clk_pin),
    .ovf_tick   (ovf_tick),
    .tmr_flag   (tmr_flag)
);

// File: tb/sim_clkout_timer.sv
module sim_clkout_timer;

    localparam int W  = 6;
    localparam int BW = W / 2;
    localparam int M  = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_en = 1'b1;
    logic          slow = 1'b0;
    logic          run = 1'b0;
    logic          ct_sel = 1'b0;
    logic          out_en = 1'b1;
    logic          gpio_latch = 1'b0;
    logic          wr_hi = 1'b0;
    logic          wr_lo = 1'b0;
    logic [BW-1:0] wdata = '0;
    logic          flag_clr = 1'b0;
    logic          clk_pin;
    logic          ovf_tick;
    logic          tmr_flag;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // osc_en: every clock, or every other clock when slow is set
    always @(negedge clk) osc_en <= slow ? ~osc_en : 1'b1;

    clkout_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .run(run), .ct_sel(ct_sel),
        .out_en(out_en), .gpio_latch(gpio_latch), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wdata(wdata), .flag_clr(flag_clr), .clk_pin(clk_pin),
        .ovf_tick(ovf_tick), .tmr_flag(tmr_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit hi, input int v);
        @(negedge clk);
        wdata = v[BW-1:0];
        wr_hi = hi;
        wr_lo = !hi;
        @(negedge clk);
        wr_hi = 1'b0;
        wr_lo = 1'b0;
    endtask

    // waits for the pin to change; returns cycle stamp, checks tick alongside
    task automatic wait_toggle(output int t);
        logic prev;
        int   lim;
        prev = clk_pin;
        lim  = 0;
        t    = -1;
        while (lim < 3000) begin
            @(negedge clk);
            lim++;
            if (clk_pin != prev) begin
                t = cyc;
                check("R5 tick with toggle", int'(ovf_tick), 1);
                lim = 3000;
            end
        end
        if (t < 0) check("R4 toggle timeout", 0, 1);
    endtask

    task automatic measure(input string req, input int r, input int scale);
        int t0, t1, t2;
        wait_toggle(t0);
        wait_toggle(t1);
        wait_toggle(t2);
        check(req, t1 - t0, 2 * scale * (M - r));
        check(req, t2 - t1, 2 * scale * (M - r));
    endtask

    task automatic quiet_window(input string req, input int len);
        logic p0;
        int   ticks;
        int   moved;
        p0 = clk_pin;
        ticks = 0;
        moved = 0;
        repeat (len) begin
            @(negedge clk);
            if (ovf_tick) ticks++;
            if (clk_pin != p0) moved++;
        end
        check(req, ticks, 0);
        check(req, moved, 0);
    endtask

    initial begin
        int t;
        int polls;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pin", int'(clk_pin), 0);
        check("R1 tick", int'(ovf_tick), 0);
        check("R1 flag", int'(tmr_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin after release", int'(clk_pin), 0);

        // R4 full sweep of reload values, osc_en every clock
        run = 1'b1;
        for (int r = 0; r < M; r++) begin
            wr_byte(1'b1, r >> BW);
            wr_byte(1'b0, r & ((1 << BW) - 1));
            measure("R4 half period", r, 1);
        end

        // R8 byte writes independent
        wr_byte(1'b1, 7);
        wr_byte(1'b0, 0);
        measure("R8 hi=7 lo=0", 56, 1);
        wr_byte(1'b0, 4);
        measure("R8 lo only -> 60", 60, 1);
        wr_byte(1'b1, 2);
        measure("R8 hi only -> 20", 20, 1);

        // R9 slow oscillator enable
        slow = 1'b1;
        foreach (t_list[i]) begin
            wr_byte(1'b1, t_list[i] >> BW);
            wr_byte(1'b0, t_list[i] & ((1 << BW) - 1));
            measure("R9 half period slow", t_list[i], 2);
        end
        slow = 1'b0;

        // R6 flag quiet in clock-out mode
        check("R6 flag quiet", int'(tmr_flag), 0);

        // R7 pin follows latch when output disabled
        wr_byte(1'b1, 6);
        wr_byte(1'b0, 0);
        @(negedge clk);
        out_en = 1'b0;
        gpio_latch = 1'b1;
        @(negedge clk);
        check("R7 pin=latch 1", int'(clk_pin), 1);
        gpio_latch = 1'b0;
        @(negedge clk);
        check("R7 pin=latch 0", int'(clk_pin), 0);

        // R6 flag set by wrap in timer mode
        polls = 0;
        while (!ovf_tick && polls < 3000) begin
            @(negedge clk);
            polls++;
        end
        check("R6 tick seen", int'(ovf_tick), 1);
        check("R6 flag set", int'(tmr_flag), 1);
        check("R7 pin still latch", int'(clk_pin), 0);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check("R6 flag cleared", int'(tmr_flag), 0);
        out_en = 1'b1;
        @(negedge clk);

        // R3 hold while stopped
        wait_toggle(t);
        run = 1'b0;
        quiet_window("R3 stopped", 400);
        run = 1'b1;
        wait_toggle(t);
        check("R3 resumes", int'(t > 0), 1);

        // R2 external counting selected: no internal counting
        ct_sel = 1'b1;
        quiet_window("R2 ext select", 400);
        ct_sel = 1'b0;
        measure("R2 resume period", 48, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    int t_list [4] = '{0, 17, 40, 63};

    // watchdog
    initial begin
        wait (cyc >= 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule